// File: doc/BRIEF.md
# Dual-Mode Serial Port with Pin Enables

This block is a byte-wide serial port that runs either as a clocked shift link or as a start/stop framed asynchronous link. A small write-only register port carries a control byte, the transmit buffer, a baud divisor and a fallback port-pin setting. Received bytes come out on a parallel bus, with a full flag that a read strobe clears. Four pins carry the serial signals: transmit data, receive data, shift clock and a receive-ready handshake. When the port is switched off, each pin falls back to a plain general-purpose pin.

Three control bits set the behaviour. The serial-enable bit only moves the pins between the serial function and the port function. It never halts or clears the transmitter. Each engine is started and stopped by its own direction enable. In clocked mode the transmitter owns the shift clock, so that clock also serves reception. As a result, the transmitter keeps running while either direction enable is set.

Top module: `sio_dual`

## Requirements
- R1: A synchronous active-high reset clears all enables, flags, shift state and port settings. After reset the transmit buffer is empty, the transmitter is idle, the receive buffer is not full and no pin is driven.
- R2: While serial-enable (control bit 0) is 0, each pin i takes its output value from port bit i (register 3 bits 3:0) and its drive enable from port bit 4+i (register 3 bits 7:4). The pin inputs always appear on `port_in`. Pins are indexed 0 transmit data, 1 receive data, 2 shift clock, 3 ready.
- R3: While the transmit engine is enabled, a write to the transmit buffer (register 1) moves the byte into the shift register and starts shifting, whatever the state of serial-enable. The buffer reads empty and the transmitter busy within three cycles.
- R4: Setting serial-enable in the middle of an internal shift puts the frame onto the transmit pin from the bit then in progress. The frame finishes at its original time and does not restart.
- R5: In asynchronous mode (control bit 3 = 0), clearing transmit-enable (control bit 1) returns the transmitter to idle with an empty buffer and a high transmit pin on the next clock. Buffer writes are ignored while transmit-enable is clear.
- R6: The asynchronous receiver oversamples by 16 and checks the start bit at its middle, so shorter glitches are rejected. It takes 8 data bits LSB first and stores the byte only when the stop bit is 1. Clearing receive-enable (control bit 2) abandons a frame in progress.
- R7: An asynchronous frame is one 0 start bit, 8 data bits LSB first and one 1 stop bit. Each bit lasts 16 ticks, and one tick comes every divisor+1 clocks (register 2).
- R8: In clocked mode (control bit 3 = 1) with serial-enable set, the shift-clock and ready pins are driven and the shift clock idles high. A transfer has 8 clock periods, with data changing on falling edges and sampled on rising edges. The ready pin is low while the receiver is enabled and its buffer is empty. In asynchronous mode the shift-clock pin is not driven.
- R9: In clocked mode the transmit engine runs while transmit-enable or receive-enable is set. Clearing only transmit-enable lets a transfer finish. Clearing both stops it at once, with the clock high.
- R10: In clocked mode reception stops when either receive-enable or serial-enable is cleared, and no byte is stored from that transfer. A later transfer is received aligned.
- R11: A completed byte sets the receive-full flag and appears on `rx_data`. A pulse on `rx_rd` clears the flag on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 transmit buffer, 2 divisor, 3 port |
| reg_wdata | input | 8 | Register write data |
| rx_rd | input | 1 | Receive buffer read strobe |
| rx_data | output | 8 | Receive buffer contents |
| tx_buf_empty | output | 1 | Transmit buffer holds no pending byte |
| tx_idle | output | 1 | Transmit shift register is not shifting |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| pin_o | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin drive enables |
| pin_i | input | 4 | Pin input values |
| port_in | output | 4 | Pin inputs seen as a general-purpose port |

## Verification
A transmitter that serial-enable wrongly resets shows up on the transmit pin within one bit time after the pins are switched to serial. The pin would read idle or a restarted start bit where the bench expects the later frame bits. A broken clocked-mode enable combination shows up as a missing or stray receive-full flag once the 8-period transfer has ended. A drifted receive sampler or a bad mid-start check gives a wrong stored byte, or a byte stored from a glitch, at the end of the frame. Edge-order faults in clocked mode appear within the same clock period, as a data-pin change that does not line up with a falling shift-clock edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int DATA_W  = 8;
    localparam int REG_W   = 8;
    localparam int DIV_W   = REG_W;
    localparam int OVS     = 16;
    localparam int FRAME_N = DATA_W + 2;
    localparam int PIN_N   = 4;

    localparam int PIN_TXD  = 0;
    localparam int PIN_RXD  = 1;
    localparam int PIN_SCLK = 2;
    localparam int PIN_SRDY = 3;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_TXBUF = 2'd1,
        REG_DIV   = 2'd2,
        REG_PORT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic sync_md;
        logic rx_en;
        logic tx_en;
        logic ser_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic logic [FRAME_N-1:0] async_frame(input logic [DATA_W-1:0] d);
        return {1'b1, d, 1'b0};
    endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sync_mode,
    input  logic              run,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              txd,
    output logic              sclk,
    output logic              smp,
    output logic              buf_empty,
    output logic              idle
);
    localparam int BC_W = $clog2(FRAME_N);
    localparam int OV_W = $clog2(OVS);
    localparam logic [BC_W-1:0] LAST_SYNC  = BC_W'(DATA_W - 1);
    localparam logic [BC_W-1:0] LAST_ASYNC = BC_W'(FRAME_N - 1);
    localparam logic [OV_W-1:0] OV_LAST    = OV_W'(OVS - 1);

    logic [DATA_W-1:0]  buf_q;
    logic               buf_full;
    logic               busy;
    logic [FRAME_N-1:0] sh;
    logic [BC_W-1:0]    bit_cnt;
    logic [OV_W-1:0]    ovs_cnt;
    logic               sclk_q;
    logic               txd_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
            busy     <= 1'b0;
            sh       <= '1;
            bit_cnt  <= '0;
            ovs_cnt  <= '0;
            sclk_q   <= 1'b1;
            txd_q    <= 1'b1;
        end else begin
            if (!busy && buf_full) begin
                busy     <= 1'b1;
                buf_full <= 1'b0;
                bit_cnt  <= '0;
                ovs_cnt  <= '0;
                sclk_q   <= 1'b1;
                if (sync_mode) begin
                    sh <= {2'b11, buf_q};
                end else begin
                    sh    <= async_frame(buf_q);
                    txd_q <= 1'b0;
                end
            end else if (busy && tick) begin
                if (sync_mode) begin
                    if (sclk_q) begin
                        sclk_q <= 1'b0;
                        txd_q  <= sh[0];
                    end else begin
                        sclk_q  <= 1'b1;
                        sh      <= {1'b1, sh[FRAME_N-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST_SYNC) busy <= 1'b0;
                    end
                end else if (ovs_cnt == OV_LAST) begin
                    ovs_cnt <= '0;
                    sh      <= {1'b1, sh[FRAME_N-1:1]};
                    txd_q   <= sh[1];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_ASYNC) begin
                        busy  <= 1'b0;
                        txd_q <= 1'b1;
                    end
                end else begin
                    ovs_cnt <= ovs_cnt + 1'b1;
                end
            end
            if (wr) begin
                buf_q    <= wdata;
                buf_full <= 1'b1;
            end
        end
    end

    assign txd       = (busy || sync_mode) ? txd_q : 1'b1;
    assign sclk      = sclk_q;
    assign smp       = busy && tick && sync_mode && !sclk_q;
    assign buf_empty = !buf_full;
    assign idle      = !busy;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sync_mode,
    input  logic              run,
    input  logic              rxd,
    input  logic              smp,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              full
);
    localparam int BC_W = $clog2(DATA_W);
    localparam int OV_W = $clog2(OVS);
    localparam logic [BC_W-1:0] BIT_LAST = BC_W'(DATA_W - 1);
    localparam logic [OV_W-1:0] OV_LAST  = OV_W'(OVS - 1);
    localparam logic [OV_W-1:0] OV_HALF  = OV_W'(OVS / 2 - 1);

    rx_state_e         st;
    logic [DATA_W-1:0] sh;
    logic [BC_W-1:0]   bit_cnt;
    logic [OV_W-1:0]   ovs_cnt;
    logic [DATA_W-1:0] data_q;
    logic              full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            sh      <= '0;
            bit_cnt <= '0;
            ovs_cnt <= '0;
            data_q  <= '0;
            full_q  <= 1'b0;
        end else begin
            if (rd) full_q <= 1'b0;
            if (!run) begin
                st      <= RX_IDLE;
                bit_cnt <= '0;
                ovs_cnt <= '0;
            end else if (sync_mode) begin
                st <= RX_IDLE;
                if (smp) begin
                    sh      <= {rxd, sh[DATA_W-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BIT_LAST) begin
                        data_q  <= {rxd, sh[DATA_W-1:1]};
                        full_q  <= 1'b1;
                        bit_cnt <= '0;
                    end
                end
            end else if (tick) begin
                case (st)
                    RX_IDLE: begin
                        if (!rxd) begin
                            st      <= RX_START;
                            ovs_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (ovs_cnt == OV_HALF) begin
                            ovs_cnt <= '0;
                            bit_cnt <= '0;
                            st      <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (ovs_cnt == OV_LAST) begin
                            ovs_cnt <= '0;
                            sh      <= {rxd, sh[DATA_W-1:1]};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == BIT_LAST) st <= RX_STOP;
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (ovs_cnt == OV_LAST) begin
                            st      <= RX_IDLE;
                            ovs_cnt <= '0;
                            if (rxd) begin
                                data_q <= sh;
                                full_q <= 1'b1;
                            end
                        end else begin
                            ovs_cnt <= ovs_cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign data = data_q;
    assign full = full_q;
endmodule

// File: rtl/sio_pins.sv
module sio_pins
    import sio_pkg::*;
(
    input  logic             ser_en,
    input  logic             sync_mode,
    input  logic             txd,
    input  logic             sclk,
    input  logic             srdy,
    input  logic [PIN_N-1:0] port_out,
    input  logic [PIN_N-1:0] port_dir,
    input  logic [PIN_N-1:0] pin_i,
    output logic [PIN_N-1:0] pin_o,
    output logic [PIN_N-1:0] pin_oe,
    output logic             rxd,
    output logic [PIN_N-1:0] port_in
);
    logic [PIN_N-1:0] ser_o;
    logic [PIN_N-1:0] ser_oe;

    always_comb begin
        ser_o  = '0;
        ser_oe = '0;
        ser_o[PIN_TXD]   = txd;
        ser_oe[PIN_TXD]  = 1'b1;
        ser_o[PIN_SCLK]  = sclk;
        ser_oe[PIN_SCLK] = sync_mode;
        ser_o[PIN_SRDY]  = srdy;
        ser_oe[PIN_SRDY] = sync_mode;
    end

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        assign pin_o[i]  = ser_en ? ser_o[i]  : port_out[i];
        assign pin_oe[i] = ser_en ? ser_oe[i] : port_dir[i];
    end

    assign rxd     = ser_en ? pin_i[PIN_RXD] : 1'b1;
    assign port_in = pin_i;
endmodule

// File: rtl/sio_dual.sv
module sio_dual
    import sio_pkg::*;
#(
    parameter int DIV_RESET = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_buf_empty,
    output logic              tx_idle,
    output logic              rx_full,
    output logic [PIN_N-1:0]  pin_o,
    output logic [PIN_N-1:0]  pin_oe,
    input  logic [PIN_N-1:0]  pin_i,
    output logic [PIN_N-1:0]  port_in
);
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [PIN_N-1:0] port_out_q;
    logic [PIN_N-1:0] port_dir_q;

    logic ser_en, sync_md, tx_run, rx_run;
    logic tick, tx_wr, txd_int, sclk_int, smp, srdy_int, rxd_int;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            div_q      <= DIV_W'(DIV_RESET);
            port_out_q <= '0;
            port_dir_q <= '0;
        end else if (reg_we) begin
            case (reg_sel_e'(reg_addr))
                REG_CTRL: ctrl_q <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
                REG_DIV:  div_q  <= reg_wdata[DIV_W-1:0];
                REG_PORT: begin
                    port_out_q <= reg_wdata[PIN_N-1:0];
                    port_dir_q <= reg_wdata[2*PIN_N-1:PIN_N];
                end
                default: ;
            endcase
        end
    end

    assign ser_en   = ctrl_q.ser_en;
    assign sync_md  = ctrl_q.sync_md;
    assign tx_run   = sync_md ? (ctrl_q.tx_en || ctrl_q.rx_en) : ctrl_q.tx_en;
    assign rx_run   = ctrl_q.rx_en && (sync_md ? ser_en : 1'b1);
    assign tx_wr    = reg_we && (reg_sel_e'(reg_addr) == REG_TXBUF);
    assign srdy_int = !(rx_run && !rx_full);

    sio_baud u_baud (
        .clk (clk),
        .rst (rst),
        .div (div_q),
        .tick(tick)
    );

    sio_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .sync_mode(sync_md),
        .run      (tx_run),
        .wr       (tx_wr),
        .wdata    (reg_wdata[DATA_W-1:0]),
        .txd      (txd_int),
        .sclk     (sclk_int),
        .smp      (smp),
        .buf_empty(tx_buf_empty),
        .idle     (tx_idle)
    );

    sio_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .sync_mode(sync_md),
        .run      (rx_run),
        .rxd      (rxd_int),
        .smp      (smp),
        .rd       (rx_rd),
        .data     (rx_data),
        .full     (rx_full)
    );

    sio_pins u_pins (
        .ser_en   (ser_en),
        .sync_mode(sync_md),
        .txd      (txd_int),
        .sclk     (sclk_int),
        .srdy     (srdy_int),
        .port_out (port_out_q),
        .port_dir (port_dir_q),
        .pin_i    (pin_i),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe),
        .rxd      (rxd_int),
        .port_in  (port_in)
    );
endmodule

// File: rtl/sio_dual_chk.sv
module sio_dual_chk
    import sio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ser_en,
    input logic             sync_md,
    input logic             tx_run,
    input logic             rx_run,
    input logic             tx_idle,
    input logic             tx_buf_empty,
    input logic             rx_full,
    input logic [PIN_N-1:0] pin_o,
    input logic [PIN_N-1:0] pin_oe,
    input logic [PIN_N-1:0] port_dir
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_idle && tx_buf_empty && !rx_full && pin_oe == '0));

    // R2
    port_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        !ser_en |-> (pin_oe == port_dir));

    // R5
    tx_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_run |=> (tx_idle && tx_buf_empty));

    // R8
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_en && sync_md && tx_idle) |-> pin_o[PIN_SCLK]);

    // R10
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(rx_run));
endmodule

bind sio_dual sio_dual_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ser_en      (ser_en),
    .sync_md     (sync_md),
    .tx_run      (tx_run),
    .rx_run      (rx_run),
    .tx_idle     (tx_idle),
    .tx_buf_empty(tx_buf_empty),
    .rx_full     (rx_full),
    .pin_o       (pin_o),
    .pin_oe      (pin_oe),
    .port_dir    (port_dir_q)
);

// File: tb/sio_dual_test.sv
module sio_dual_test;
    localparam logic [1:0] A_CTRL = 2'd0, A_TX = 2'd1, A_DIV = 2'd2, A_PORT = 2'd3;
    localparam int NV = 8;
    // bit 8 = clocked mode, bits 7:0 = byte sent over loopback
    localparam logic [8:0] VEC [NV] = '{9'h055, 9'h000, 9'h0FF, 9'h0A3,
                                        9'h13C, 9'h181, 9'h1FE, 9'h101};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       tx_buf_empty, tx_idle, rx_full;
    logic [3:0] pin_o, pin_oe, pin_i, port_in;
    logic [3:0] drv = 4'hF;
    logic       loop_en = 1'b0;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign pin_i = {drv[3:2], (loop_en ? pin_o[0] : drv[1]), drv[0]};

    sio_dual uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .rx_rd(rx_rd), .rx_data(rx_data),
        .tx_buf_empty(tx_buf_empty), .tx_idle(tx_idle), .rx_full(rx_full),
        .pin_o(pin_o), .pin_oe(pin_oe), .pin_i(pin_i), .port_in(port_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic skip(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wait_rx(input int lim);
        for (int n = 0; n < lim && !rx_full; n++) @(negedge clk);
    endtask

    task automatic wait_idle(input int lim);
        for (int n = 0; n < lim && !tx_idle; n++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input int len);
        drv[1] = b;
        skip(len);
    endtask

    task automatic send_frame(input logic [7:0] d);
        send_bit(1'b0, 32);
        for (int k = 0; k < 8; k++) send_bit(d[k], 32);
        send_bit(1'b1, 32);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [9:0] frame;
        int c0, falls, bad;
        logic ps, pt;

        skip(3);
        rst = 1'b0;
        skip(1);
        // R1 reset state
        chk("R1 tx_buf_empty", tx_buf_empty, 1);
        chk("R1 tx_idle", tx_idle, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 pin_oe", pin_oe, 4'h0);

        // R2 port fallback: dir 1010, out 0101
        wr(A_PORT, 8'hA5);
        drv = 4'b1011;
        skip(1);
        chk("R2 pin_oe", pin_oe, 4'hA);
        chk("R2 pin_o", pin_o, 4'h5);
        chk("R2 port_in", port_in, 4'b1011);
        drv = 4'hF;

        // R3 / R4: transmit enabled, serial pins off, frame shifts internally
        wr(A_CTRL, 8'h02);
        wr(A_TX, 8'h96);
        c0 = cyc;
        frame = {1'b1, 8'h96, 1'b0};
        skip(3);
        chk("R3 buffer moved", tx_buf_empty, 1);
        chk("R3 shifting", tx_idle, 0);
        chk("R3 pin is port", pin_o[0], 1);
        chk("R3 pin not driven", pin_oe[0], 0);
        wait_until(c0 + 17 + 32 * 4);
        wr(A_CTRL, 8'h03);
        for (int k = 5; k < 10; k++) begin
            wait_until(c0 + 17 + 32 * k);
            chk($sformatf("R4 R7 frame bit %0d", k), pin_o[0], frame[k]);
            chk("R4 pin driven", pin_oe[0], 1);
        end
        wait_until(c0 + 17 + 32 * 10);
        chk("R4 no restart idle", tx_idle, 1);
        chk("R4 line high", pin_o[0], 1);
        chk("R8 sclk undriven async", pin_oe[2], 0);

        // R5 async transmit stop
        wr(A_TX, 8'h00);
        c0 = cyc;
        wait_until(c0 + 17 + 32);
        chk("R7 data bit0 on line", pin_o[0], 0);
        wr(A_CTRL, 8'h01);
        skip(1);
        chk("R5 idle after stop", tx_idle, 1);
        chk("R5 line high", pin_o[0], 1);
        wr(A_TX, 8'h00);
        skip(1);
        chk("R5 write ignored", tx_buf_empty, 1);
        wr(A_CTRL, 8'h03);
        skip(40);
        chk("R5 nothing resumed", tx_idle, 1);
        chk("R5 line still high", pin_o[0], 1);

        // R6 async receive from bench-driven line
        loop_en = 1'b0;
        drv[1] = 1'b1;
        wr(A_CTRL, 8'h05);
        skip(20);
        send_frame(8'h5A);
        wait_rx(40);
        chk("R6 byte stored", rx_full, 1);
        chk("R6 byte value", rx_data, 8'h5A);
        rd_pulse();
        chk("R11 cleared by read", rx_full, 0);
        send_bit(1'b0, 4);
        send_bit(1'b1, 400);
        chk("R6 glitch rejected", rx_full, 0);
        for (int k = 0; k < 10; k++) begin
            if (k == 4) wr(A_CTRL, 8'h01);
            send_bit((k == 0) ? 1'b0 : (k == 9) ? 1'b1 : 1'b1, (k == 4) ? 30 : 32);
        end
        chk("R6 abandoned on disable", rx_full, 0);
        wr(A_CTRL, 8'h05);
        skip(40);
        chk("R6 no late store", rx_full, 0);
        send_bit(1'b0, 32);
        for (int k = 0; k < 8; k++) send_bit(k[0], 32);
        send_bit(1'b0, 24);
        send_bit(1'b1, 100);
        chk("R6 bad stop rejected", rx_full, 0);
        send_frame(8'hE1);
        wait_rx(40);
        chk("R6 recovers value", rx_data, 8'hE1);
        rd_pulse();

        // vector table over loopback
        loop_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, {4'b0, VEC[i][8], 3'b111});
            wr(A_TX, VEC[i][7:0]);
            wait_rx(800);
            chk("R11 full set", rx_full, 1);
            chk(VEC[i][8] ? "R8 clocked loopback" : "R7 async loopback", rx_data, VEC[i][7:0]);
            rd_pulse();
            chk("R11 read clears", rx_full, 0);
            wait_idle(400);
        end

        // R8 clocked pin behaviour
        wr(A_CTRL, 8'h0F);
        skip(2);
        chk("R8 sclk idles high", pin_o[2], 1);
        chk("R8 sclk driven", pin_oe[2], 1);
        chk("R8 ready low", pin_o[3], 0);
        wr(A_TX, 8'hA5);
        falls = 0; bad = 0;
        ps = pin_o[2]; pt = pin_o[0];
        repeat (80) begin
            @(negedge clk);
            if (ps && !pin_o[2]) falls++;
            if (pin_o[0] !== pt && !(ps && !pin_o[2])) bad++;
            ps = pin_o[2]; pt = pin_o[0];
        end
        chk("R8 eight clock periods", falls, 8);
        chk("R8 data moves on falling edge", bad, 0);
        chk("R8 sclk high after", pin_o[2], 1);
        chk("R8 ready high when full", pin_o[3], 1);
        chk("R8 byte", rx_data, 8'hA5);
        rd_pulse();

        // R9 clearing only transmit enable lets the transfer finish
        wr(A_TX, 8'h6B);
        skip(8);
        wr(A_CTRL, 8'h0D);
        wait_rx(80);
        chk("R9 transfer finished", rx_full, 1);
        chk("R9 byte", rx_data, 8'h6B);
        rd_pulse();
        wr(A_CTRL, 8'h0F);
        wr(A_TX, 8'h6B);
        skip(8);
        wr(A_CTRL, 8'h09);
        skip(1);
        chk("R9 both cleared stops", tx_idle, 1);
        chk("R9 sclk high", pin_o[2], 1);
        skip(60);
        chk("R9 no byte", rx_full, 0);

        // R10 clocked receive stops on serial-enable or receive-enable
        wr(A_CTRL, 8'h0F);
        wr(A_TX, 8'h6B);
        skip(8);
        wr(A_CTRL, 8'h0E);
        skip(60);
        chk("R10 ser off no byte", rx_full, 0);
        chk("R9 tx ran to end", tx_idle, 1);
        wr(A_CTRL, 8'h0F);
        wr(A_TX, 8'h24);
        wait_rx(80);
        chk("R10 realigned byte", rx_data, 8'h24);
        rd_pulse();
        wr(A_TX, 8'h77);
        skip(8);
        wr(A_CTRL, 8'h0B);
        skip(60);
        chk("R10 rx off no byte", rx_full, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule